// File: doc/BRIEF.md
# Status and Clock Output Pin Selector

This block decides what two general-purpose pins carry when they act as outputs. Each pin has a 3-bit function code and an inversion bit. The code either leaves the pin as an input, or routes one internal source to it. The sources are a temperature-good flag, an auto-mute flag, a PLL-locked flag, a fixed level, or a divided copy of the PLL clock.

A small divider runs on the PLL clock and divides it by 1, 2, 3 or 4 according to a 2-bit ratio field. A new ratio is taken up only when the current output period ends, so the pins never see a truncated pulse. When the control interface runs in its three-wire mode, pin A is needed as a chip-select input, so the mode flag overrides pin A's code.

The two pins encode their fixed levels in opposite order. Software that copies a code from one pin to the other gets the opposite level.

Top module: `gpio_out_mux`

## Requirements
- R1: Function codes 3'b000 and 3'b001 leave a pin as an input: output enable 0 and output value 0, whatever the inversion bit holds.
- R2: Codes 3'b010, 3'b011 and 3'b101 drive the temperature-good, auto-mute and PLL-locked flags respectively, with output enable 1.
- R3: On pin A, code 3'b110 drives 0 and code 3'b111 drives 1.
- R4: On pin B, code 3'b110 drives 1 and code 3'b111 drives 0.
- R5: When a pin's inversion bit is 1 and the pin is an output, its value is the complement of the selected source.
- R6: While `three_wire` is 1, pin A is an input (enable 0, value 0) whatever its code holds. Pin B is unaffected.
- R7: Code 3'b100 drives the divided PLL clock. Ratio 2'b00 passes the PLL clock unchanged: high after its rising edge and low after its falling edge.
- R8: Ratio 2'b01 gives one PLL cycle high, then one low.
- R9: Ratio 2'b10 gives two PLL cycles high, then one low.
- R10: Ratio 2'b11 gives two PLL cycles high, then two low.
- R11: A ratio change is taken up at the first rising edge after the current period ends. The first rising edge after reset release starts a high phase of the ratio present at that edge.
- R12: Inversion also applies to the divided clock output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | PLL clock, drives the divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| three_wire | input | 1 | Control interface in three-wire mode; pin A becomes an input |
| temp_good | input | 1 | Temperature-good flag |
| amute_on | input | 1 | Auto-mute active flag |
| pll_locked | input | 1 | PLL lock flag |
| func_a | input | 3 | Pin A function code |
| inv_a | input | 1 | Pin A output inversion |
| func_b | input | 3 | Pin B function code |
| inv_b | input | 1 | Pin B output inversion |
| clk_ratio | input | 2 | Divider ratio code (00 = /1, 01 = /2, 10 = /3, 11 = /4) |
| pin_a_out | output | 1 | Pin A output value |
| pin_a_oe | output | 1 | Pin A output enable |
| pin_b_out | output | 1 | Pin B output value |
| pin_b_oe | output | 1 | Pin B output enable |

## Verification
The bench first drives the same constant-level codes on both pins in one vector. A design that shares one level table between the pins then fails on pin B.

The reserved code is paired with the inversion bit set. A design that inverts before gating by the enable would show a 1 on an input pin.

The divider is followed cycle by cycle at every ratio, including divide-by-1, where the bench also samples the falling half-cycle. A design whose divide-by-3 output is a plain toggle, or that swaps the duty pattern, goes out of step within three cycles. The ratio is also changed halfway through a divide-by-4 period. A design that applies the change at once would shorten that period and produce a runt pulse.

// File: rtl/gpio_out_mux.sv
module gpio_out_mux (
  input  logic       clk_pll,
  input  logic       rst_n,
  input  logic       three_wire,
  input  logic       temp_good,
  input  logic       amute_on,
  input  logic       pll_locked,
  input  logic [2:0] func_a,
  input  logic       inv_a,
  input  logic [2:0] func_b,
  input  logic       inv_b,
  input  logic [1:0] clk_ratio,
  output logic       pin_a_out,
  output logic       pin_a_oe,
  output logic       pin_b_out,
  output logic       pin_b_oe
);

  localparam logic [2:0] F_TEMP  = 3'b010;
  localparam logic [2:0] F_MUTE  = 3'b011;
  localparam logic [2:0] F_CLK   = 3'b100;
  localparam logic [2:0] F_LOCK  = 3'b101;
  localparam logic [2:0] F_LEV_X = 3'b110;
  localparam logic [2:0] F_LEV_Y = 3'b111;

  // divider: phase counter, ratio in force, registered divided clock
  logic [1:0] phase, phase_n;
  logic [1:0] ratio_q, ratio_n;
  logic [1:0] hi_len_n;
  logic       wrap;
  logic       div_q;
  logic       clk_src;

  assign wrap     = (phase == ratio_q);
  assign phase_n  = wrap ? 2'd0 : phase + 2'd1;
  assign ratio_n  = wrap ? clk_ratio : ratio_q;
  assign hi_len_n = ratio_n[1] ? 2'd2 : 2'd1;

  always_ff @(posedge clk_pll or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= 2'd0;
      ratio_q <= 2'd0;
      div_q   <= 1'b0;
    end else begin
      phase   <= phase_n;
      ratio_q <= ratio_n;
      div_q   <= (phase_n < hi_len_n);
    end
  end

  assign clk_src = (ratio_q == 2'd0) ? clk_pll : div_q;

  // pin A
  logic [2:0] eff_a;
  logic       val_a;
  assign eff_a = three_wire ? 3'b000 : func_a;

  always_comb begin
    case (eff_a)
      F_TEMP:  val_a = temp_good;
      F_MUTE:  val_a = amute_on;
      F_CLK:   val_a = clk_src;
      F_LOCK:  val_a = pll_locked;
      F_LEV_X: val_a = 1'b0;
      F_LEV_Y: val_a = 1'b1;
      default: val_a = 1'b0;
    endcase
  end

  assign pin_a_oe  = (eff_a[2:1] != 2'b00);
  assign pin_a_out = pin_a_oe & (val_a ^ inv_a);

  // pin B: fixed levels in the opposite order
  logic val_b;

  always_comb begin
    case (func_b)
      F_TEMP:  val_b = temp_good;
      F_MUTE:  val_b = amute_on;
      F_CLK:   val_b = clk_src;
      F_LOCK:  val_b = pll_locked;
      F_LEV_X: val_b = 1'b1;
      F_LEV_Y: val_b = 1'b0;
      default: val_b = 1'b0;
    endcase
  end

  assign pin_b_oe  = (func_b[2:1] != 2'b00);
  assign pin_b_out = pin_b_oe & (val_b ^ inv_b);

  a_r1_input_quiet_a: assert property (@(posedge clk_pll) disable iff (!rst_n)
    !pin_a_oe |-> !pin_a_out);
  a_r1_input_quiet_b: assert property (@(posedge clk_pll) disable iff (!rst_n)
    !pin_b_oe |-> !pin_b_out);
  a_r6_three_wire_input: assert property (@(posedge clk_pll) disable iff (!rst_n)
    three_wire |-> !pin_a_oe);
  a_r9_single_low: assert property (@(posedge clk_pll) disable iff (!rst_n)
    (ratio_q == 2'd2 && !div_q) |=> div_q);
  a_r10_phase_range: assert property (@(posedge clk_pll) disable iff (!rst_n)
    phase <= ratio_q);
  a_r11_ratio_held: assert property (@(posedge clk_pll) disable iff (!rst_n)
    (phase != ratio_q) |=> $stable(ratio_q));

endmodule

// File: tb/test_gpio_out_mux.sv
module test_gpio_out_mux;
  logic       clk_pll = 1'b0;
  logic       rst_n = 1'b0;
  logic       three_wire = 1'b0;
  logic       temp_good = 1'b0, amute_on = 1'b0, pll_locked = 1'b0;
  logic [2:0] func_a = 3'b000, func_b = 3'b000;
  logic       inv_a = 1'b0, inv_b = 1'b0;
  logic [1:0] clk_ratio = 2'b00;
  logic       pin_a_out, pin_a_oe, pin_b_out, pin_b_oe;

  int n_chk = 0, n_bad = 0;
  int ph = 0, act = 0;

  always #4 clk_pll = ~clk_pll;

  gpio_out_mux i_gpio_out_mux (
    .clk_pll(clk_pll), .rst_n(rst_n), .three_wire(three_wire),
    .temp_good(temp_good), .amute_on(amute_on), .pll_locked(pll_locked),
    .func_a(func_a), .inv_a(inv_a), .func_b(func_b), .inv_b(inv_b),
    .clk_ratio(clk_ratio),
    .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe),
    .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe));

  // fields: three_wire, func_a, inv_a, func_b, inv_b, temp, mute, lock,
  //         exp a_oe, exp a_out, exp b_oe, exp b_out
  localparam int NV = 15;
  localparam logic [15:0] VEC [NV] = '{
    16'b0_000_0_000_0_111_0000, // R1
    16'b0_001_1_001_1_111_0000, // R1 reserved with inversion
    16'b0_010_0_010_0_100_1111, // R2
    16'b0_010_0_010_0_011_1010, // R2
    16'b0_011_0_011_0_010_1111, // R2
    16'b0_011_0_101_0_101_1011, // R2
    16'b0_101_0_101_0_000_1010, // R2
    16'b0_110_0_110_0_000_1011, // R3 R4
    16'b0_111_0_111_0_111_1110, // R3 R4
    16'b0_110_1_110_1_000_1110, // R5
    16'b0_111_1_111_1_000_1011, // R5
    16'b0_010_1_011_1_100_1011, // R5
    16'b1_111_0_111_0_000_0010, // R6
    16'b1_010_1_101_1_101_0010, // R6
    16'b1_000_0_110_0_000_0011  // R6
  };

  task automatic check(input string tag, input logic act_v, input logic exp_v, input string what);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  // follow the divider from the requirements; pin A plain, pin B inverted
  task automatic run(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      logic e;
      @(posedge clk_pll);
      if (ph == act) begin ph = 0; act = int'(clk_ratio); end
      else ph++;
      e = (act == 0) ? 1'b1 : (ph < ((act >= 2) ? 2 : 1));
      #2;
      check(tag, pin_a_out, e, "clk pin A");
      check("R12", pin_b_out, ~e, "clk pin B inverted");
      if (act == 0) begin
        @(negedge clk_pll); #2;
        check(tag, pin_a_out, 1'b0, "clk pin A low half");
        check("R12", pin_b_out, 1'b1, "clk pin B low half");
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_pll);
    #1;
    check("R1", pin_a_oe, 1'b0, "reset pin A enable");
    check("R1", pin_b_oe, 1'b0, "reset pin B enable");
    @(negedge clk_pll);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [15:0] w;
      w = VEC[v];
      @(negedge clk_pll);
      {three_wire, func_a, inv_a, func_b, inv_b, temp_good, amute_on, pll_locked} = w[15:4];
      #2;
      check($sformatf("vector %0d R1-6", v), pin_a_oe,  w[3], "pin A enable");
      check($sformatf("vector %0d R1-6", v), pin_a_out, w[2], "pin A value");
      check($sformatf("vector %0d R1-6", v), pin_b_oe,  w[1], "pin B enable");
      check($sformatf("vector %0d R1-6", v), pin_b_out, w[0], "pin B value");
    end

    // divided clock; reset restart with ratio /4 present (R11)
    @(negedge clk_pll);
    three_wire = 1'b0;
    func_a = 3'b100; inv_a = 1'b0;
    func_b = 3'b100; inv_b = 1'b1;
    clk_ratio = 2'b11;
    rst_n = 1'b0;
    @(negedge clk_pll);
    ph = 0; act = 0;
    rst_n = 1'b1;
    run(1, "R11");
    run(9, "R10");
    // mid-period change from /4 to /2 (R11)
    run(1, "R10");
    clk_ratio = 2'b01;
    run(8, "R11");
    run(8, "R8");
    clk_ratio = 2'b10;
    run(12, "R9");
    clk_ratio = 2'b00;
    run(8, "R7");
    clk_ratio = 2'b10;
    run(7, "R9");
    clk_ratio = 2'b11;
    run(2, "R11");
    run(8, "R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule